// File: doc/BRIEF.md
# SPI Flash Command Engine

This block runs single SPI flash transactions on request from software. Software programs a setup word, an opcode, a flash address and a byte count through a small byte-addressed register window. It then writes a start request. The engine selects one of two flash devices and sends the opcode, followed by up to four address bytes and an optional run of dummy clocks. It then moves data between the flash and a 256-byte local buffer, in either direction. Software learns that the transaction is complete by polling a busy flag or by reading a sticky completion flag.

The same engine serves commands that carry no address, such as status or identification reads, and it also serves page programming. The setup word sets the address length, so a length of zero skips the address phase. A two-bit operating-mode field guards the engine. While that field is all ones (memory-mapped mode, the reset state), start requests are refused. Returning the field to zero (register mode) is accepted only right after a fixed two-byte unlock written to the opcode register.

The serial side uses SPI mode 0 with a fixed clock divider. The buffer has its own byte port for software.

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset both chip selects are high, SCLK is low, the control byte reads 0x30 (mode field all ones, not busy) and the status byte reads 0.
- R2: Register window offsets: setup word at 0x0–0x3 (byte 0 least significant), control at 0x4, opcode at 0x5, byte count at 0x6–0x7 (low byte first), flash address at 0x8–0xB (low byte first), status at 0xC. Setup, opcode, count and address read back what was written.
- R3: Control bits: 0 = start (always reads 0), 1 = busy (read-only), 3 = direction (1 = buffer to flash, 0 = flash to buffer), 5:4 = mode. Writing 11 to the mode field always takes effect. A start request while the mode field (before the write) is not 00 is ignored.
- R4: A mode write other than 11 takes effect only when the two register writes just before it were 0x55 and then 0xAA to the opcode register. Otherwise the mode is unchanged.
- R5: On start, setup bit 24 picks the device: 0 drives cs_n[0] low and 1 drives cs_n[1] low. Only one select is low, and it stays low for the whole transaction.
- R6: The frame is sent MSB first in this order: the opcode, then the low N bytes of the address with the most significant first (N = setup bits 18:16, values above 4 act as 4), then D dummy clocks with MOSI low (D = setup bits 23:19), then the data. SCLK idles low, MOSI changes on falling edges and MISO is sampled on rising edges.
- R7: In a write, data bytes come from buffer indices 0, 1, 2 and so on, in order.
- R8: In a read, received bytes go into buffer indices 0 upward, and MOSI is low during the data phase.
- R9: A byte count above 256 moves 256 bytes. A count of 0 ends the frame after the address and dummy phases.
- R10: Busy reads 1 from the cycle after the start write until the cycle the chip select rises, and then reads 0.
- R11: While busy, writes to the setup, opcode, count, address or buffer are ignored.
- R12: Status bit 0 is set when a transaction completes and cleared by writing 1 to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| buf_wr | input | 1 | Buffer write strobe |
| buf_addr | input | 8 | Buffer byte index |
| buf_wdata | input | 8 | Buffer write data |
| buf_rdata | output | 8 | Buffer read data at buf_addr |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |
| spi_cs_n | output | 2 | Active-low chip selects |

## Verification
A bad phase counter shows up at the pins within one byte time: the captured bit stream is shorter or longer than the expected length, or bits are out of place. A wrong buffer index shows up in the first data byte, either on MOSI or in the buffer read-back after the transaction. Errors in mode and unlock state show up on the next start request, which either selects a device when it should not or fails to select one when it should. A missing write guard shows up in the register or buffer read-back right after the busy flag falls.

// File: rtl/fce_pkg.sv
package fce_pkg;

  localparam logic [3:0] OFS_CFG   = 4'h0;
  localparam logic [3:0] OFS_CTRL  = 4'h4;
  localparam logic [3:0] OFS_OPC   = 4'h5;
  localparam logic [3:0] OFS_CNT   = 4'h6;
  localparam logic [3:0] OFS_ADDR  = 4'h8;
  localparam logic [3:0] OFS_STAT  = 4'hC;

  localparam logic [7:0] UNLOCK_A  = 8'h55;
  localparam logic [7:0] UNLOCK_B  = 8'hAA;
  localparam logic [1:0] MODE_MMAP = 2'b11;
  localparam logic [1:0] MODE_REG  = 2'b00;

  typedef enum logic [2:0] {
    PH_IDLE, PH_CMD, PH_ADDR, PH_DUMMY, PH_DATA, PH_END
  } phase_t;

  function automatic logic [15:0] clamp_count(input logic [15:0] c, input int unsigned lim);
    if (32'(c) > lim) return 16'(lim);
    return c;
  endfunction

  function automatic logic [2:0] clamp_abytes(input logic [2:0] n, input int unsigned maxb);
    if (32'(n) > maxb) return 3'(maxb);
    return n;
  endfunction

  function automatic logic [3:0] chunk_bits(input logic [4:0] rem);
    if (rem >= 5'd8) return 4'd8;
    return rem[3:0];
  endfunction

  function automatic phase_t follow_on(input phase_t done_ph, input logic has_addr,
                                       input logic has_dummy, input logic has_data);
    if (done_ph == PH_CMD && has_addr) return PH_ADDR;
    if ((done_ph == PH_CMD || done_ph == PH_ADDR) && has_dummy) return PH_DUMMY;
    if (done_ph != PH_DATA && has_data) return PH_DATA;
    return PH_END;
  endfunction

endpackage

// File: rtl/fce_buffer.sv
module fce_buffer #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [7:0]    rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [7:0]    rdata_b
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/fce_shifter.sv
module fce_shifter #(
  parameter int CLK_DIV = 2,
  localparam int DCW = $clog2(CLK_DIV) + 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx,
  input  logic [3:0] nbits,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx
);
  logic [DCW-1:0] divcnt;
  logic           half;
  logic           active;
  logic [7:0]     shreg;
  logic [7:0]     rxreg;
  logic [3:0]     left;
  logic           done_q;
  logic           tick;

  assign tick = (divcnt == DCW'(CLK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divcnt <= '0;
      half   <= 1'b0;
      active <= 1'b0;
      shreg  <= '0;
      rxreg  <= '0;
      left   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go && !active) begin
        active <= 1'b1;
        half   <= 1'b0;
        divcnt <= '0;
        shreg  <= tx;
        left   <= nbits;
      end else if (active) begin
        if (tick) begin
          divcnt <= '0;
          if (!half) begin
            half  <= 1'b1;
            rxreg <= {rxreg[6:0], miso};
          end else begin
            half  <= 1'b0;
            shreg <= {shreg[6:0], 1'b0};
            left  <= left - 4'd1;
            if (left == 4'd1) begin
              active <= 1'b0;
              done_q <= 1'b1;
            end
          end
        end else begin
          divcnt <= divcnt + DCW'(1);
        end
      end
    end
  end

  assign sclk = half;
  assign mosi = active & shreg[7];
  assign busy = active;
  assign done = done_q;
  assign rx   = rxreg;
endmodule

// File: rtl/fce_seq.sv
module fce_seq
  import fce_pkg::*;
#(
  parameter int CLK_DIV = 2,
  parameter int DEPTH   = 256,
  parameter int FADDR_W = 32,
  parameter int CNT_W   = 16,
  localparam int AW     = $clog2(DEPTH),
  localparam int RW     = $clog2(DEPTH) + 1,
  localparam int ABYTES = FADDR_W / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               cfg_cs,
  input  logic [2:0]         cfg_abytes,
  input  logic [4:0]         cfg_dummy,
  input  logic [7:0]         opcode,
  input  logic [CNT_W-1:0]   count,
  input  logic [FADDR_W-1:0] faddr,
  input  logic               dir,
  input  logic [7:0]         buf_rdata,
  output logic [AW-1:0]      buf_idx,
  output logic               buf_we,
  output logic [7:0]         buf_wdata,
  output logic               busy,
  output logic               done_evt,
  output logic               spi_sclk,
  output logic               spi_mosi,
  input  logic               spi_miso,
  output logic [1:0]         spi_cs_n
);
  phase_t             phase;
  logic               waiting;
  logic               sel_q;
  logic               dir_q;
  logic [7:0]         opc_q;
  logic [FADDR_W-1:0] ash;
  logic [2:0]         arem;
  logic [4:0]         drem;
  logic [RW-1:0]      data_rem;
  logic [AW-1:0]      idx;
  logic [2:0]         nab;
  logic               go;
  logic [7:0]         tx;
  logic [3:0]         nbits;
  logic               sh_busy;
  logic               sh_done;
  logic [7:0]         sh_rx;
  logic [3:0]         dchunk;

  assign nab    = clamp_abytes(cfg_abytes, ABYTES);
  assign dchunk = chunk_bits(drem);
  assign go     = (phase == PH_CMD || phase == PH_ADDR || phase == PH_DUMMY ||
                   phase == PH_DATA) && !waiting;

  always_comb begin
    tx    = 8'h00;
    nbits = 4'd8;
    unique case (phase)
      PH_CMD:   tx = opc_q;
      PH_ADDR:  tx = ash[FADDR_W-1 -: 8];
      PH_DUMMY: nbits = dchunk;
      PH_DATA:  tx = dir_q ? buf_rdata : 8'h00;
      default:  tx = 8'h00;
    endcase
  end

  fce_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (go),
    .tx   (tx),
    .nbits(nbits),
    .miso (spi_miso),
    .sclk (spi_sclk),
    .mosi (spi_mosi),
    .busy (sh_busy),
    .done (sh_done),
    .rx   (sh_rx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      waiting  <= 1'b0;
      sel_q    <= 1'b0;
      dir_q    <= 1'b0;
      opc_q    <= '0;
      ash      <= '0;
      arem     <= '0;
      drem     <= '0;
      data_rem <= '0;
      idx      <= '0;
    end else begin
      if (phase == PH_IDLE) begin
        if (start) begin
          sel_q    <= cfg_cs;
          dir_q    <= dir;
          opc_q    <= opcode;
          ash      <= faddr << (8 * (ABYTES - int'(nab)));
          arem     <= nab;
          drem     <= cfg_dummy;
          data_rem <= RW'(clamp_count(count, DEPTH));
          idx      <= '0;
          waiting  <= 1'b0;
          phase    <= PH_CMD;
        end
      end else if (phase == PH_END) begin
        phase <= PH_IDLE;
      end else if (go) begin
        waiting <= 1'b1;
      end else if (sh_done) begin
        waiting <= 1'b0;
        unique case (phase)
          PH_CMD: phase <= follow_on(PH_CMD, arem != '0, drem != '0, data_rem != '0);
          PH_ADDR: begin
            ash  <= ash << 8;
            arem <= arem - 3'd1;
            if (arem == 3'd1) phase <= follow_on(PH_ADDR, 1'b0, drem != '0, data_rem != '0);
          end
          PH_DUMMY: begin
            drem <= drem - 5'(dchunk);
            if (drem == 5'(dchunk)) phase <= follow_on(PH_DUMMY, 1'b0, 1'b0, data_rem != '0);
          end
          PH_DATA: begin
            idx      <= idx + AW'(1);
            data_rem <= data_rem - RW'(1);
            if (data_rem == RW'(1)) phase <= PH_END;
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  assign busy      = (phase != PH_IDLE);
  assign done_evt  = (phase == PH_END);
  assign buf_idx   = idx;
  assign buf_we    = (phase == PH_DATA) && sh_done && !dir_q;
  assign buf_wdata = sh_rx;
  assign spi_cs_n  = !busy ? 2'b11 : (sel_q ? 2'b01 : 2'b10);

  // R9: remaining data never exceeds the buffer size
  a_r9_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
    data_rem <= RW'(DEPTH));

  // R5: at most one device selected
  a_r5_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~spi_cs_n));

  // R6: a new byte is issued only when the shifter is idle
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !sh_busy);
endmodule

// File: rtl/fce_regs.sv
module fce_regs
  import fce_pkg::*;
#(
  parameter int FADDR_W = 32,
  parameter int CNT_W   = 16,
  localparam int FB     = FADDR_W / 8,
  localparam int CB     = CNT_W / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [3:0]         reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  input  logic               seq_busy,
  input  logic               done_evt,
  output logic               cfg_cs,
  output logic [2:0]         cfg_abytes,
  output logic [4:0]         cfg_dummy,
  output logic [7:0]         opcode,
  output logic [CNT_W-1:0]   count,
  output logic [FADDR_W-1:0] faddr,
  output logic               dir,
  output logic               start_pulse,
  output logic               busy_view
);
  logic [31:0]        cfg_q;
  logic [7:0]         opc_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FADDR_W-1:0] addr_q;
  logic               dir_q;
  logic [1:0]         mode_q;
  logic               start_q;
  logic               seen_a;
  logic               armed_q;
  logic               done_q;
  logic               wr_ok;
  logic               ctrl_wr;
  logic               start_req;

  assign busy_view = seq_busy | start_q;
  assign wr_ok     = reg_wr & ~busy_view;
  assign ctrl_wr   = wr_ok && (reg_addr == OFS_CTRL);
  assign start_req = ctrl_wr && reg_wdata[0] && (mode_q == MODE_REG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      opc_q   <= '0;
      cnt_q   <= '0;
      addr_q  <= '0;
      dir_q   <= 1'b0;
      mode_q  <= MODE_MMAP;
      start_q <= 1'b0;
      seen_a  <= 1'b0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      start_q <= start_req;
      if (reg_wr) begin
        seen_a  <= (reg_addr == OFS_OPC) && (reg_wdata == UNLOCK_A);
        armed_q <= (reg_addr == OFS_OPC) && (reg_wdata == UNLOCK_B) && seen_a;
      end
      if (wr_ok) begin
        for (int i = 0; i < 4; i++)
          if (reg_addr == OFS_CFG + 4'(i)) cfg_q[8*i +: 8] <= reg_wdata;
        for (int i = 0; i < CB; i++)
          if (reg_addr == OFS_CNT + 4'(i)) cnt_q[8*i +: 8] <= reg_wdata;
        for (int i = 0; i < FB; i++)
          if (reg_addr == OFS_ADDR + 4'(i)) addr_q[8*i +: 8] <= reg_wdata;
        if (reg_addr == OFS_OPC) opc_q <= reg_wdata;
      end
      if (ctrl_wr) begin
        dir_q <= reg_wdata[3];
        if (reg_wdata[5:4] == MODE_MMAP || armed_q) mode_q <= reg_wdata[5:4];
      end
      if (done_evt) done_q <= 1'b1;
      else if (reg_wr && reg_addr == OFS_STAT && reg_wdata[0]) done_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    for (int i = 0; i < 4; i++)
      if (reg_addr == OFS_CFG + 4'(i)) reg_rdata = cfg_q[8*i +: 8];
    for (int i = 0; i < CB; i++)
      if (reg_addr == OFS_CNT + 4'(i)) reg_rdata = cnt_q[8*i +: 8];
    for (int i = 0; i < FB; i++)
      if (reg_addr == OFS_ADDR + 4'(i)) reg_rdata = addr_q[8*i +: 8];
    if (reg_addr == OFS_CTRL) reg_rdata = {2'b00, mode_q, dir_q, 1'b0, busy_view, 1'b0};
    if (reg_addr == OFS_OPC)  reg_rdata = opc_q;
    if (reg_addr == OFS_STAT) reg_rdata = {7'b0, done_q};
  end

  assign cfg_cs      = cfg_q[24];
  assign cfg_abytes  = cfg_q[18:16];
  assign cfg_dummy   = cfg_q[23:19];
  assign opcode      = opc_q;
  assign count       = cnt_q;
  assign faddr       = addr_q;
  assign dir         = dir_q;
  assign start_pulse = start_q;

  // R4: leaving the all-ones mode needs the unlock pair just before
  a_r4_unlock_needed: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(mode_q) && mode_q != MODE_MMAP) |-> $past(armed_q));

  // R12: completion sets the sticky flag
  a_r12_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> done_q);

  // R11: address and count frozen under busy writes
  a_r11_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_view && reg_wr) |=> ($stable(addr_q) && $stable(cnt_q) && $stable(opc_q)));

  // R10: an accepted start selects a device on the next cycle
  a_r10_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> seq_busy);
endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine #(
  parameter int CLK_DIV = 2,
  parameter int DEPTH   = 256,
  parameter int FADDR_W = 32,
  parameter int CNT_W   = 16,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [3:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          buf_wr,
  input  logic [AW-1:0] buf_addr,
  input  logic [7:0]    buf_wdata,
  output logic [7:0]    buf_rdata,
  output logic          spi_sclk,
  output logic          spi_mosi,
  input  logic          spi_miso,
  output logic [1:0]    spi_cs_n
);
  logic               cfg_cs;
  logic [2:0]         cfg_abytes;
  logic [4:0]         cfg_dummy;
  logic [7:0]         opcode;
  logic [CNT_W-1:0]   count;
  logic [FADDR_W-1:0] faddr;
  logic               dir;
  logic               start_pulse;
  logic               busy_view;
  logic               seq_busy;
  logic               done_evt;
  logic [AW-1:0]      seq_idx;
  logic               seq_we;
  logic [7:0]         seq_wdata;
  logic [7:0]         seq_rdata;
  logic               mem_we;
  logic [AW-1:0]      mem_waddr;
  logic [7:0]         mem_wdata;

  fce_regs #(.FADDR_W(FADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .seq_busy   (seq_busy),
    .done_evt   (done_evt),
    .cfg_cs     (cfg_cs),
    .cfg_abytes (cfg_abytes),
    .cfg_dummy  (cfg_dummy),
    .opcode     (opcode),
    .count      (count),
    .faddr      (faddr),
    .dir        (dir),
    .start_pulse(start_pulse),
    .busy_view  (busy_view)
  );

  fce_seq #(.CLK_DIV(CLK_DIV), .DEPTH(DEPTH), .FADDR_W(FADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_pulse),
    .cfg_cs    (cfg_cs),
    .cfg_abytes(cfg_abytes),
    .cfg_dummy (cfg_dummy),
    .opcode    (opcode),
    .count     (count),
    .faddr     (faddr),
    .dir       (dir),
    .buf_rdata (seq_rdata),
    .buf_idx   (seq_idx),
    .buf_we    (seq_we),
    .buf_wdata (seq_wdata),
    .busy      (seq_busy),
    .done_evt  (done_evt),
    .spi_sclk  (spi_sclk),
    .spi_mosi  (spi_mosi),
    .spi_miso  (spi_miso),
    .spi_cs_n  (spi_cs_n)
  );

  assign mem_we    = seq_we | (buf_wr & ~busy_view);
  assign mem_waddr = seq_we ? seq_idx : buf_addr;
  assign mem_wdata = seq_we ? seq_wdata : buf_wdata;

  fce_buffer #(.DEPTH(DEPTH)) u_buf (
    .clk    (clk),
    .we     (mem_we),
    .waddr  (mem_waddr),
    .wdata  (mem_wdata),
    .raddr_a(buf_addr),
    .rdata_a(buf_rdata),
    .raddr_b(seq_idx),
    .rdata_b(seq_rdata)
  );

  // R6: the serial clock stays low whenever no device is selected
  a_r6_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (&spi_cs_n) |-> !spi_sclk);

  // R10: a device is selected in the cycle after an accepted start
  a_r10_select_follows: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> (spi_cs_n != 2'b11));
endmodule

// File: tb/flash_cmd_engine_test.sv
`timescale 1ns/1ps
module flash_cmd_engine_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       buf_wr = 1'b0;
  logic [7:0] buf_addr = '0;
  logic [7:0] buf_wdata = '0;
  logic [7:0] buf_rdata;
  logic       spi_sclk, spi_mosi, spi_miso;
  logic [1:0] spi_cs_n;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  flash_cmd_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .buf_wr(buf_wr),
    .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n)
  );

  // flash model: records MOSI on rising SCLK, serves a bit pattern on MISO
  logic       cap [0:8191];
  int         capn = 0;
  int         stray = 0;
  logic [1:0] cs_seen = 2'b11;

  function automatic logic bitval(input int n);
    logic [31:0] h;
    h = 32'(n) * 32'h9E3779B1;
    return h[17] ^ h[5];
  endfunction

  assign spi_miso = bitval(capn);

  always @(posedge spi_sclk) begin
    if (spi_cs_n != 2'b11) begin
      if (capn < 8192) cap[capn] = spi_mosi;
      capn = capn + 1;
      cs_seen = spi_cs_n;
    end else begin
      stray = stray + 1;
    end
  end

  logic [7:0] exp_buf [0:255];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic bwr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    buf_wr = 1'b1; buf_addr = a; buf_wdata = d;
    @(negedge clk);
    buf_wr = 1'b0;
  endtask

  task automatic brd(input logic [7:0] a, output logic [7:0] d);
    buf_addr = a;
    #1;
    d = buf_rdata;
  endtask

  function automatic int clampi(input int v, input int lim);
    return (v > lim) ? lim : v;
  endfunction

  task automatic run_txn(input bit cs, input int nab, input int dummy, input logic [7:0] opc,
                         input logic [31:0] addr, input int count, input bit dirw,
                         input bit inject, input string tag);
    int nabc, ncnt, base, total, k, bad, firstbad;
    logic [7:0] d, got, expb;
    logic expbits [0:8191];
    nabc = clampi(nab, 4);
    ncnt = clampi(count, 256);
    wr(4'h0, 8'h00); wr(4'h1, 8'h00);
    wr(4'h2, {5'(dummy), 3'(nab)});
    wr(4'h3, {7'b0, cs});
    for (int i = 0; i < 4; i++) wr(4'h8 + 4'(i), addr[8*i +: 8]);
    wr(4'h5, opc);
    wr(4'h6, count[7:0]); wr(4'h7, count[15:8]);
    wr(4'hC, 8'h01);
    if (dirw) begin
      for (int i = 0; i < ncnt; i++) begin
        exp_buf[i] = 8'($urandom);
        bwr(8'(i), exp_buf[i]);
      end
    end
    base = capn;
    wr(4'h4, {4'b0000, dirw, 3'b001});
    rd(4'h4, d);
    check(d[1] == 1'b1 && d[0] == 1'b0, {"R10 busy after start ", tag}, d, 8'h02);
    @(negedge clk);
    check(spi_cs_n == (cs ? 2'b01 : 2'b10), {"R5 select ", tag}, spi_cs_n, cs ? 1 : 2);
    if (inject) begin
      repeat (5) @(negedge clk);
      wr(4'h8, ~addr[7:0]);
      wr(4'h5, ~opc);
      wr(4'h6, 8'h01);
      bwr(8'h00, ~exp_buf[0]);
    end
    for (int t = 0; t < 60000; t++) begin
      rd(4'h4, d);
      if (d[1] == 1'b0) break;
      @(negedge clk);
    end
    check(d[1] == 1'b0 && spi_cs_n == 2'b11, {"R10 busy falls with select ", tag}, {d, 6'b0, spi_cs_n}, 0);
    // expected MOSI stream
    k = 0;
    for (int b = 7; b >= 0; b--) begin expbits[k] = opc[b]; k++; end
    for (int a = nabc - 1; a >= 0; a--)
      for (int b = 7; b >= 0; b--) begin expbits[k] = addr[8*a + b]; k++; end
    for (int z = 0; z < dummy; z++) begin expbits[k] = 1'b0; k++; end
    for (int i = 0; i < ncnt; i++)
      for (int b = 7; b >= 0; b--) begin
        expbits[k] = dirw ? exp_buf[i][b] : 1'b0; k++;
      end
    total = k;
    check(capn - base == total, {"R6 R9 frame length ", tag}, capn - base, total);
    bad = 0; firstbad = -1;
    for (int i = 0; i < total && i < capn - base; i++)
      if (cap[base + i] !== expbits[i]) begin
        bad++;
        if (firstbad < 0) firstbad = i;
      end
    check(bad == 0, {dirw ? "R6 R7 MOSI stream " : "R6 R8 MOSI stream ", tag}, firstbad, -1);
    check(cs_seen == (cs ? 2'b01 : 2'b10) || total == 0, {"R5 device ", tag}, cs_seen, cs ? 1 : 2);
    if (!dirw && ncnt > 0) begin
      bad = 0; firstbad = -1;
      for (int i = 0; i < ncnt; i++) begin
        for (int b = 0; b < 8; b++)
          expb[7 - b] = bitval(base + 8 + 8*nabc + dummy + 8*i + b);
        brd(8'(i), got);
        if (got !== expb) begin
          bad++;
          if (firstbad < 0) firstbad = i;
        end
      end
      check(bad == 0, {"R8 read buffer ", tag}, firstbad, -1);
    end
    rd(4'hC, d);
    check(d == 8'h01, {"R12 done set ", tag}, d, 1);
    wr(4'hC, 8'h01);
    rd(4'hC, d);
    check(d == 8'h00, {"R12 done cleared ", tag}, d, 0);
    if (inject) begin
      rd(4'h8, d);
      check(d == addr[7:0], "R11 address kept", d, addr[7:0]);
      rd(4'h5, d);
      check(d == opc, "R11 opcode kept", d, opc);
      rd(4'h6, d);
      check(d == count[7:0], "R11 count kept", d, count[7:0]);
      brd(8'h00, d);
      check(d == exp_buf[0], "R11 buffer kept", d, exp_buf[0]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int sc;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    rd(4'h4, d);
    check(d == 8'h30, "R1 control reset", d, 8'h30);
    rd(4'hC, d);
    check(d == 8'h00, "R1 status reset", d, 0);
    check(spi_cs_n == 2'b11 && spi_sclk == 1'b0, "R1 pins idle", {spi_cs_n, spi_sclk}, 6);
    // R2 readback
    wr(4'h0, 8'h12); wr(4'h1, 8'h34); wr(4'h2, 8'h56); wr(4'h3, 8'h78);
    wr(4'h6, 8'h9A); wr(4'h7, 8'hBC);
    wr(4'h8, 8'hDE); wr(4'h9, 8'hF0); wr(4'hA, 8'h11); wr(4'hB, 8'h22);
    wr(4'h5, 8'h33);
    begin
      logic [7:0] expv [0:11];
      expv = '{8'h12, 8'h34, 8'h56, 8'h78, 8'h30, 8'h33, 8'h9A, 8'hBC, 8'hDE, 8'hF0, 8'h11, 8'h22};
      for (int i = 0; i < 12; i++) begin
        if (i == 4) continue;
        rd(4'(i), d);
        check(d == expv[i], "R2 register readback", d, expv[i]);
      end
    end
    // R3: start refused in mode 11
    sc = capn;
    wr(4'h4, 8'h31);
    rd(4'h4, d);
    repeat (20) @(negedge clk);
    check(d == 8'h30 && spi_cs_n == 2'b11 && capn == sc, "R3 start ignored in mapped mode", d, 8'h30);
    // R4: clear without unlock
    wr(4'h4, 8'h00);
    rd(4'h4, d);
    check(d[5:4] == 2'b11, "R4 clear without unlock ignored", d, 8'h30);
    wr(4'h5, 8'h55); wr(4'h6, 8'h00); wr(4'h5, 8'hAA); wr(4'h4, 8'h00);
    rd(4'h4, d);
    check(d[5:4] == 2'b11, "R4 broken unlock ignored", d, 8'h30);
    wr(4'h5, 8'h55); wr(4'h5, 8'hAA); wr(4'h4, 8'h00);
    rd(4'h4, d);
    check(d == 8'h00, "R4 unlock then clear", d, 8'h00);
    // directed transactions
    run_txn(1'b0, 0, 0, 8'h9F, 32'h0, 3, 1'b0, 1'b0, "id read");
    run_txn(1'b1, 3, 0, 8'h02, 32'h00ABCDEF, 300, 1'b1, 1'b0, "R9 saturate");
    run_txn(1'b0, 4, 9, 8'h0B, 32'h89ABCDEF, 0, 1'b1, 1'b0, "R9 zero count");
    run_txn(1'b1, 7, 3, 8'h3B, 32'hCAFEF00D, 5, 1'b0, 1'b0, "nab clamp");
    run_txn(1'b0, 2, 0, 8'h02, 32'h00001234, 10, 1'b1, 1'b1, "busy guard");
    for (int n = 0; n < 10; n++) begin
      run_txn(1'($urandom), int'($urandom % 5), int'($urandom % 13), 8'($urandom),
              $urandom, int'($urandom % 25), 1'($urandom), 1'b0, "random");
    end
    check(stray == 0, "R6 no clock while deselected", stray, 0);
    // R3: writing 11 returns to mapped mode
    wr(4'h4, 8'h30);
    rd(4'h4, d);
    check(d == 8'h30, "R3 mode set to 11", d, 8'h30);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule